// File: doc/BRIEF.md
# Write-Masked GPIO Bank Controller

This block controls a bank of 32 general-purpose pins from a simple memory-mapped register bus that has single-cycle read and write strobes. Four control registers each hold 16 bits: output levels for the lower and upper halves of the bank, and pin directions for the same two halves. Every bus write carries its own per-bit enable in the upper half of the word. Software can therefore set, clear or leave alone any subset of 16 pins in one write, without reading the register first.

The pad side is modelled as an output-level vector and an output-enable vector, plus a raw input vector. The input vector passes through a synchronizer and can then be read as one word. A fixed identification word lets software recognise the register layout. Read data is registered and appears one clock after the read strobe.

Top module: `pinbank_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it is released, every output-level bit, every direction bit, `pad_out`, `pad_oe` and `rdata` are 0, so every pin is an input.
- R2: A write to offset 0x00 updates the levels of pins 0–15, and a write to offset 0x04 updates the levels of pins 16–31. Word bit 16+n enables bit n of that half to take word bit n. A bit whose enable is 0 keeps its value.
- R3: A write to offset 0x08 updates the directions of pins 0–15, and a write to offset 0x0C updates the directions of pins 16–31. The enables work as in R2.
- R4: For every pin n, `pad_oe[n]` equals its direction bit (1 = output) and `pad_out[n]` equals its level bit. Writing the level first and the direction second raises the enable with the level already in place, so `pad_out` does not change on the cycle the enable rises.
- R5: A read of 0x00, 0x04, 0x08 or 0x0C returns the stored 16 bits in bits 15:0 and 0 in bits 31:16.
- R6: A read of 0x70 returns the pin inputs with bit n for pin n. The inputs pass through two register stages, so a read captured at clock edge k returns `pad_in` as it was sampled at edge k−2.
- R7: A read of 0x78 returns 0x01000C2B.
- R8: A read of any other address, including addresses that are not multiples of 4, returns 0. A write to 0x70, to 0x78 or to any undefined address changes no register.
- R9: `rdata` loads only at a clock edge where `rd_en` is high, and otherwise keeps its value. When a read and a write occur in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write word: bits 31:16 are enables, bits 15:0 are values |
| rdata | output | 32 | Registered read word |
| pad_in | input | 32 | Raw levels seen on the pins |
| pad_out | output | 32 | Level driven on each pin |
| pad_oe | output | 32 | Output enable of each pin |

## Verification
The assertions assume that the strobes, address and write word are stable around each rising edge and carry no X after reset. They also assume that `pad_in` may change in any cycle, because the synchronizer check compares against the input two edges back and not against settled values. The bench drives every bus input on the falling edge, so each value is held for a full half period on both sides of the sampling edge. It changes `pad_in` both between reads and directly before reads, to cover each point of the two-stage latency. Writes that overlap reads and writes whose enables are all zero are also in the stimulus, so the hold and read-before-write cases are exercised.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

   // Control register indices; byte offset of each is 4 * index.
   localparam int unsigned NUM_CTRL    = 4;
   localparam int unsigned CR_LVL_LO   = 0;
   localparam int unsigned CR_LVL_HI   = 1;
   localparam int unsigned CR_DIR_LO   = 2;
   localparam int unsigned CR_DIR_HI   = 3;

   localparam int unsigned OFS_PADS    = 32'h70;
   localparam int unsigned OFS_IDENT   = 32'h78;
   localparam logic [31:0] IDENT_WORD  = 32'h0100_0C2B;

   function automatic int unsigned ctrl_offset(input int unsigned idx);
      return idx * 4;
   endfunction

endpackage

// File: rtl/pinbank_maskreg.sv
module pinbank_maskreg #(
   parameter int unsigned HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [2*HALF_W-1:0] wword,
   output logic [HALF_W-1:0]   q
);
   localparam int unsigned WORD_W = 2 * HALF_W;

   initial begin
      if (HALF_W < 1) $error("pinbank_maskreg: HALF_W must be at least 1");
   end

   logic [HALF_W-1:0] en_bits;
   logic [HALF_W-1:0] val_bits;

   assign en_bits  = wword[WORD_W-1:HALF_W];
   assign val_bits = wword[HALF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= (q & ~en_bits) | (val_bits & en_bits);
   end

   AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (((q ^ $past(q)) & ~$past(wword[WORD_W-1:HALF_W])) == '0)); // R2, R3
   AST_MASKED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (((q ^ $past(wword[HALF_W-1:0])) & $past(wword[WORD_W-1:HALF_W])) == '0)); // R2, R3
   AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q)); // R8

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   initial begin
      if (STAGES < 2 || STAGES > 4) $error("pinbank_sync: STAGES must be 2..4");
      if (WIDTH < 1) $error("pinbank_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/pinbank_rdmux.sv
module pinbank_rdmux
   import pinbank_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned HALF_W = 16,
   parameter logic [2*HALF_W-1:0] IDENT = '0
) (
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [NUM_CTRL-1:0][HALF_W-1:0]    ctrl,
   input  logic [2*HALF_W-1:0]                pads,
   output logic [2*HALF_W-1:0]                word
);
   always_comb begin
      word = '0;
      for (int unsigned i = 0; i < NUM_CTRL; i++) begin
         if (addr == ADDR_W'(ctrl_offset(i))) word = {{HALF_W{1'b0}}, ctrl[i]};
      end
      if (addr == ADDR_W'(OFS_PADS))  word = pads;
      if (addr == ADDR_W'(OFS_IDENT)) word = IDENT;
   end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
   import pinbank_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [NPINS-1:0] IDENT  = NPINS'(IDENT_WORD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NPINS-1:0]  wdata,
   output logic [NPINS-1:0]  rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe
);
   localparam int unsigned HALF_W = NPINS / 2;

   initial begin
      if (NPINS % 2 != 0 || NPINS < 2) $error("pinbank_ctrl: NPINS must be even");
      if (ADDR_W < 7) $error("pinbank_ctrl: ADDR_W must reach offset 0x78");
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) $error("pinbank_ctrl: SYNC_STAGES 2..4");
   end

   logic [NUM_CTRL-1:0][HALF_W-1:0] ctrl_q;
   logic [NPINS-1:0]                pads_sync;
   logic [NPINS-1:0]                rd_word;

   // One masked half-register per control offset.
   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
      logic sel;
      assign sel = wr_en && (addr == ADDR_W'(ctrl_offset(i)));
      pinbank_maskreg #(.HALF_W(HALF_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (sel),
         .wword (wdata),
         .q     (ctrl_q[i])
      );
   end

   assign pad_out = {ctrl_q[CR_LVL_HI], ctrl_q[CR_LVL_LO]};
   assign pad_oe  = {ctrl_q[CR_DIR_HI], ctrl_q[CR_DIR_LO]};

   pinbank_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (pads_sync)
   );

   pinbank_rdmux #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .IDENT(IDENT)) u_rdmux (
      .addr (addr),
      .ctrl (ctrl_q),
      .pads (pads_sync),
      .word (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
   end

   // Cycles since reset release, saturating; gates the latency check.
   logic [2:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           warm <= '0;
      else if (warm != '1)  warm <= warm + 3'd1;
   end

   logic rd_ctrl;
   logic rd_undef;
   assign rd_ctrl  = (addr == ADDR_W'(ctrl_offset(CR_LVL_LO))) || (addr == ADDR_W'(ctrl_offset(CR_LVL_HI)))
                  || (addr == ADDR_W'(ctrl_offset(CR_DIR_LO))) || (addr == ADDR_W'(ctrl_offset(CR_DIR_HI)));
   assign rd_undef = !rd_ctrl && (addr != ADDR_W'(OFS_PADS)) && (addr != ADDR_W'(OFS_IDENT));

   AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(warm) > SYNC_STAGES) |-> (pads_sync == $past(pad_in, SYNC_STAGES))); // R6
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R9
   AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(OFS_IDENT)) |=> (rdata == IDENT)); // R7
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_ctrl) |=> (rdata[NPINS-1:HALF_W] == '0)); // R5
   AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_undef) |=> (rdata == '0)); // R8

endmodule

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;

   always #10 clk = ~clk;   // 50 MHz

   pinbank_ctrl u_pinbank_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   int compared = 0;
   int mismatched = 0;
   string tag = "R1";

   // Behavioural reference model
   logic [15:0] m_lvl [2];
   logic [15:0] m_dir [2];
   logic [31:0] m_rdata;
   logic [31:0] m_hist [$];

   function automatic logic [15:0] mask_upd(logic [15:0] old, logic [31:0] w);
      logic [15:0] r = old;
      for (int b = 0; b < 16; b++) if (w[16+b]) r[b] = w[b];
      return r;
   endfunction

   function automatic logic [31:0] m_read(logic [7:0] a, logic [31:0] vis);
      case (a)
         8'h00:   return {16'h0, m_lvl[0]};
         8'h04:   return {16'h0, m_lvl[1]};
         8'h08:   return {16'h0, m_dir[0]};
         8'h0C:   return {16'h0, m_dir[1]};
         8'h70:   return vis;
         8'h78:   return 32'h0100_0C2B;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lvl[0] = '0; m_lvl[1] = '0; m_dir[0] = '0; m_dir[1] = '0;
         m_rdata = '0;
         m_hist = {32'h0, 32'h0};
      end else begin
         logic [31:0] vis;
         vis = m_hist[0];
         if (rd_en) m_rdata = m_read(addr, vis);
         if (wr_en) begin
            case (addr)
               8'h00: m_lvl[0] = mask_upd(m_lvl[0], wdata);
               8'h04: m_lvl[1] = mask_upd(m_lvl[1], wdata);
               8'h08: m_dir[0] = mask_upd(m_dir[0], wdata);
               8'h0C: m_dir[1] = mask_upd(m_dir[1], wdata);
               default: ;
            endcase
         end
         void'(m_hist.pop_front());
         m_hist.push_back(pad_in);
      end
   end

   task automatic compare_now();
      logic [31:0] e_out, e_oe;
      e_out = {m_lvl[1], m_lvl[0]};
      e_oe  = {m_dir[1], m_dir[0]};
      compared++;
      if (rdata !== m_rdata || pad_out !== e_out || pad_oe !== e_oe) begin
         mismatched++;
         $display("FAIL %s rdata=%h exp=%h pad_out=%h exp=%h pad_oe=%h exp=%h",
                  tag, rdata, m_rdata, pad_out, e_out, pad_oe, e_oe);
      end
   endtask

   // Compare every cycle, 5 ns after the rising edge.
   bit run_cmp = 1'b0;
   always @(posedge clk) begin
      #5;
      if (run_cmp) compare_now();
   end

   task automatic op(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d;
   endtask
   task automatic wr(input logic [7:0] a, input logic [31:0] d); op(1'b1, 1'b0, a, d); endtask
   task automatic rd(input logic [7:0] a); op(1'b0, 1'b1, a, 32'h0); endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(1'b0, 1'b0, 8'h00, 32'h0);
   endtask

   bit done = 1'b0;
   initial begin
      #(20 * 200000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      // R1: reset state, during and right after reset
      tag = "R1";
      pad_in = 32'hDEAD_BEEF;
      repeat (3) @(posedge clk);
      #5 compare_now();
      run_cmp = 1'b1;
      @(negedge clk) rst_n = 1'b1;
      idle(3);

      // R2: masked level writes, both halves, and an all-zero mask
      tag = "R2";
      wr(8'h00, 32'hFFFF_A5A5);
      wr(8'h00, 32'h00F0_0F0F);
      wr(8'h04, 32'h8001_FFFF);
      wr(8'h04, 32'h0000_FFFF);
      wr(8'h00, 32'h0000_0000);
      idle(1);

      // R5: readback of all four control registers
      tag = "R5";
      rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
      idle(1);

      // R3: masked direction writes
      tag = "R3";
      wr(8'h08, 32'h00FF_0055);
      wr(8'h0C, 32'hF000_A000);
      wr(8'h08, 32'h000F_0000);
      rd(8'h08); rd(8'h0C);

      // R4: program pin 20 high as output: level first, then direction
      tag = "R4";
      wr(8'h04, 32'h0010_0010);
      wr(8'h0C, 32'h0010_0010);
      idle(1);
      if (pad_out[20] !== 1'b1 || pad_oe[20] !== 1'b1) begin
         mismatched++;
         $display("FAIL R4 pin20 out=%b oe=%b exp 1 1", pad_out[20], pad_oe[20]);
      end
      compared++;
      wr(8'h00, 32'h0002_0000);   // pin 1 low, then output
      wr(8'h08, 32'h0002_0002);
      idle(1);

      // R6: pad input synchronizer latency
      tag = "R6";
      pad_in = 32'h1234_5678;
      idle(3);
      rd(8'h70);
      @(negedge clk) begin pad_in = 32'hCAFE_F00D; rd_en = 1'b1; addr = 8'h70; wr_en = 1'b0; end
      rd(8'h70); rd(8'h70); rd(8'h70);
      pad_in = 32'h0F0F_0F0F;
      rd(8'h70); rd(8'h70);
      idle(1);

      // R7: identification word
      tag = "R7";
      rd(8'h78);
      idle(1);

      // R8: undefined and read-only addresses
      tag = "R8";
      rd(8'h10); rd(8'h74); rd(8'h7C); rd(8'h01); rd(8'hFC);
      wr(8'h70, 32'hFFFF_FFFF);
      wr(8'h78, 32'hFFFF_FFFF);
      wr(8'h20, 32'hFFFF_0000);
      wr(8'h02, 32'hFFFF_FFFF);
      rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
      idle(1);

      // R9: rdata holds; read/write in the same cycle returns old value
      tag = "R9";
      rd(8'h78);
      idle(4);
      op(1'b1, 1'b1, 8'h00, 32'hFFFF_1357);
      op(1'b0, 1'b1, 8'h00, 32'h0);
      idle(2);

      // Mixed pseudo-random traffic against the model
      tag = "R2";
      lfsr = 32'hACE1_2345;
      for (int i = 0; i < 400; i++) begin
         logic [7:0] a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         case (lfsr[2:0])
            3'd0: a = 8'h00; 3'd1: a = 8'h04; 3'd2: a = 8'h08; 3'd3: a = 8'h0C;
            3'd4: a = 8'h70; 3'd5: a = 8'h78; default: a = {lfsr[13:8], 2'b00};
         endcase
         if (lfsr[5]) pad_in = lfsr ^ 32'h5A5A_A5A5;
         op(lfsr[3], lfsr[4], a, {lfsr[15:0], lfsr[31:16]});
      end
      idle(2);

      run_cmp = 1'b0;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule